// File: doc/BRIEF.md
# Bounded Downward-Growing Hardware Stack with Postfix Evaluation

This block is a last-in first-out store of eleven words, held in a local array. It has a pointer that moves toward lower addresses as the stack fills. Location 10 is the bottom of the stack and location 0 is the last free slot. The pointer rests at 11 when the stack is empty. A push first decrements the pointer and then writes the incoming word at the new address. A pop first copies the addressed word into the output data register and then increments the pointer. The full and empty flags are registers. Each is set or cleared from the pointer value that results from the operation, not from a separate occupancy count.

The block also evaluates postfix expressions. An add or multiply command takes the two topmost entries, combines them, and leaves the result as the new top in a single cycle. The net effect on the pointer is one step toward the bottom. Illegal commands leave all state unchanged and raise a one-cycle error pulse. These are a push into a full stack, a pop from an empty stack, and arithmetic with fewer than two entries.

Every command takes effect at one rising clock edge, and its results are visible on the outputs right after that edge.

Top module: `lifo_stack_engine`

## Requirements
- R1: When `rst` is high at a rising edge, the pointer becomes 11, `empty_o` becomes 1, and `full_o`, `err_o` and `dout_o` become 0.
- R2: A push (`op_i` = 1) on a stack that is not full decrements the pointer by one, stores `din_i` at the new pointer value, and clears `empty_o`.
- R3: `full_o` becomes 1 exactly when a push leaves the pointer at 0, which is after the eleventh stored entry. It stays 0 while the pointer is above 0.
- R4: A pop (`op_i` = 2) on a stack that is not empty loads the word at the pointer into `dout_o`, increments the pointer by one, and clears `full_o`. Words come out in the reverse of the order they were pushed.
- R5: `empty_o` becomes 1 exactly when a pop or an arithmetic command leaves the pointer at 11.
- R6: A push while the stack is full changes no stored word, pointer or flag, and drives `err_o` high for exactly one cycle.
- R7: A pop while the stack is empty leaves the pointer and `dout_o` unchanged, and drives `err_o` high for exactly one cycle.
- R8: An add command (`op_i` = 3) with at least two entries replaces the two top entries with their sum modulo 2^16, and increments the pointer by one.
- R9: A multiply command (`op_i` = 4) with at least two entries replaces the two top entries with the low 16 bits of their product, and increments the pointer by one.
- R10: An add or multiply command with fewer than two entries (pointer above 9) is rejected. The pointer and the stored words stay as they were, and `err_o` pulses high for one cycle.
- R11: Command codes 0, 5, 6 and 7 do nothing: no state changes and `err_o` stays 0.
- R12: The sequence push 3, push 4, multiply, push 5, push 6, multiply, add leaves a single entry of 42. A following pop returns 42 and reports the stack empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Command: 0 idle, 1 push, 2 pop, 3 add, 4 multiply, 5 to 7 idle |
| din_i | input | 16 | Word to push |
| dout_o | output | 16 | Data register, loaded by each accepted pop |
| sp_o | output | 4 | Current stack pointer, 11 when empty, 0 when full |
| full_o | output | 1 | Stack full flag |
| empty_o | output | 1 | Stack empty flag |
| err_o | output | 1 | One-cycle pulse for a rejected command |

## Verification
A pointer that is off by one shows up on `sp_o` at the edge of the faulty command. It also shows up one pop later as a wrong word on `dout_o`, because the next pop reads the wrong slot. A flag that disagrees with the pointer is visible on the same edge as that command. A store corrupted by an ignored push or a misplaced arithmetic write stays hidden until the pops reach that slot. For that reason the bench drains the stack after every fill and every evaluation sequence, and compares each popped word.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

    localparam int unsigned STK_DEPTH = 11;
    localparam int unsigned STK_WIDTH = 16;

    typedef enum logic [2:0] {
        OP_IDLE = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_ADD  = 3'd3,
        OP_MUL  = 3'd4
    } stk_op_e;

    // One decoded command for the current cycle.
    typedef struct packed {
        logic push;
        logic pop;
        logic fold;      // binary arithmetic accepted
        logic fold_mul;  // 1: multiply, 0: add
        logic reject;    // command refused
    } stk_step_t;

    function automatic int unsigned ptr_bits(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/lifo_decode.sv
module lifo_decode
    import lifo_pkg::*;
#(
    parameter int unsigned DEPTH = STK_DEPTH,
    parameter int unsigned PTR_W = ptr_bits(STK_DEPTH)
) (
    input  logic [2:0]       op_i,
    input  logic [PTR_W-1:0] sp_i,
    output stk_step_t        step_o
);
    localparam logic [PTR_W-1:0] SP_BOTTOM = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] SP_TWO    = PTR_W'(DEPTH - 2);

    logic is_full;
    logic is_empty;
    logic has_two;

    assign is_full  = (sp_i == '0);
    assign is_empty = (sp_i == SP_BOTTOM);
    assign has_two  = (sp_i <= SP_TWO);

    always_comb begin
        step_o = '0;
        case (op_i)
            OP_PUSH: begin
                step_o.push   = !is_full;
                step_o.reject = is_full;
            end
            OP_POP: begin
                step_o.pop    = !is_empty;
                step_o.reject = is_empty;
            end
            OP_ADD, OP_MUL: begin
                step_o.fold     = has_two;
                step_o.fold_mul = (op_i == OP_MUL);
                step_o.reject   = !has_two;
            end
            default: step_o = '0;
        endcase
    end
endmodule

// File: rtl/lifo_ptr.sv
module lifo_ptr
    import lifo_pkg::*;
#(
    parameter int unsigned DEPTH = STK_DEPTH,
    parameter int unsigned PTR_W = ptr_bits(STK_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  stk_step_t        step_i,
    output logic [PTR_W-1:0] sp_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             err_o
);
    localparam logic [PTR_W-1:0] SP_BOTTOM = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] ONE       = PTR_W'(1);

    logic [PTR_W-1:0] sp_nxt;

    always_comb begin
        if (step_i.push)
            sp_nxt = sp_o - ONE;
        else if (step_i.pop || step_i.fold)
            sp_nxt = sp_o + ONE;
        else
            sp_nxt = sp_o;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_o    <= SP_BOTTOM;
            full_o  <= 1'b0;
            empty_o <= 1'b1;
            err_o   <= 1'b0;
        end else begin
            sp_o  <= sp_nxt;
            err_o <= step_i.reject;
            if (step_i.push) begin
                full_o  <= (sp_nxt == '0);
                empty_o <= 1'b0;
            end else if (step_i.pop || step_i.fold) begin
                full_o  <= 1'b0;
                empty_o <= (sp_nxt == SP_BOTTOM);
            end
        end
    end
endmodule

// File: rtl/lifo_alu.sv
module lifo_alu
    import lifo_pkg::*;
#(
    parameter int unsigned WIDTH = STK_WIDTH
) (
    input  logic [WIDTH-1:0] top_i,
    input  logic [WIDTH-1:0] next_i,
    input  logic             mul_i,
    output logic [WIDTH-1:0] res_o
);
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] prod;

    assign sum   = next_i + top_i;
    assign prod  = next_i * top_i;
    assign res_o = mul_i ? prod : sum;
endmodule

// File: rtl/lifo_store.sv
module lifo_store
    import lifo_pkg::*;
#(
    parameter int unsigned DEPTH = STK_DEPTH,
    parameter int unsigned WIDTH = STK_WIDTH,
    parameter int unsigned PTR_W = ptr_bits(STK_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  stk_step_t        step_i,
    input  logic [PTR_W-1:0] sp_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic [WIDTH-1:0] fold_res_i,
    output logic [WIDTH-1:0] top_o,
    output logic [WIDTH-1:0] next_o,
    output logic [WIDTH-1:0] dout_o
);
    localparam logic [PTR_W-1:0] SP_BOTTOM = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] ONE       = PTR_W'(1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] sp_plus;
    logic [PTR_W-1:0] top_idx;
    logic [PTR_W-1:0] next_idx;
    logic [PTR_W-1:0] wr_idx;
    logic [WIDTH-1:0] wr_data;
    logic             wr_en;
    logic [DEPTH-1:0] wr_hit;

    assign sp_plus  = sp_i + ONE;
    // Clamp read addresses into the array when the pointer rests past it.
    assign top_idx  = (sp_i < SP_BOTTOM) ? sp_i : '0;
    assign next_idx = (sp_plus < SP_BOTTOM) ? sp_plus : '0;
    assign top_o    = mem[top_idx];
    assign next_o   = mem[next_idx];

    // Push writes below the current top; a fold overwrites the second entry.
    assign wr_en   = step_i.push || step_i.fold;
    assign wr_idx  = step_i.push ? (sp_i - ONE) : sp_plus;
    assign wr_data = step_i.push ? din_i : fold_res_i;

    for (genvar g = 0; g < DEPTH; g++) begin : g_sel
        assign wr_hit[g] = wr_en && (wr_idx == PTR_W'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
            dout_o <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++)
                if (wr_hit[i])
                    mem[i] <= wr_data;
            if (step_i.pop)
                dout_o <= top_o;
        end
    end
endmodule

// File: rtl/lifo_stack_engine.sv
module lifo_stack_engine
    import lifo_pkg::*;
#(
    parameter int unsigned DEPTH = STK_DEPTH,
    parameter int unsigned WIDTH = STK_WIDTH
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [2:0]                      op_i,
    input  logic [WIDTH-1:0]                din_i,
    output logic [WIDTH-1:0]                dout_o,
    output logic [$clog2(DEPTH+1)-1:0]      sp_o,
    output logic                            full_o,
    output logic                            empty_o,
    output logic                            err_o
);
    localparam int unsigned PTR_W = $clog2(DEPTH + 1);

    stk_step_t        step;
    logic [WIDTH-1:0] top_word;
    logic [WIDTH-1:0] next_word;
    logic [WIDTH-1:0] fold_res;

    lifo_decode #(.DEPTH(DEPTH), .PTR_W(PTR_W)) decode_i (
        .op_i   (op_i),
        .sp_i   (sp_o),
        .step_o (step)
    );

    lifo_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) ptr_i (
        .clk     (clk),
        .rst     (rst),
        .step_i  (step),
        .sp_o    (sp_o),
        .full_o  (full_o),
        .empty_o (empty_o),
        .err_o   (err_o)
    );

    lifo_alu #(.WIDTH(WIDTH)) alu_i (
        .top_i  (top_word),
        .next_i (next_word),
        .mul_i  (step.fold_mul),
        .res_o  (fold_res)
    );

    lifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PTR_W(PTR_W)) store_i (
        .clk        (clk),
        .rst        (rst),
        .step_i     (step),
        .sp_i       (sp_o),
        .din_i      (din_i),
        .fold_res_i (fold_res),
        .top_o      (top_word),
        .next_o     (next_word),
        .dout_o     (dout_o)
    );
endmodule

// File: rtl/lifo_stack_engine_chk.sv
module lifo_stack_engine_chk
    import lifo_pkg::*;
#(
    parameter int unsigned DEPTH = STK_DEPTH,
    parameter int unsigned WIDTH = STK_WIDTH,
    parameter int unsigned PTR_W = ptr_bits(STK_DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       op_i,
    input logic [WIDTH-1:0] dout_o,
    input logic [PTR_W-1:0] sp_o,
    input logic             full_o,
    input logic             empty_o,
    input logic             err_o
);
    a_r3_full_tracks_ptr: assert property (@(posedge clk) disable iff (rst)
        full_o == (sp_o == '0));

    a_r5_empty_tracks_ptr: assert property (@(posedge clk) disable iff (rst)
        empty_o == (sp_o == PTR_W'(DEPTH)));

    a_r2_push_steps_down: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_PUSH && !full_o) |=> (sp_o == $past(sp_o) - PTR_W'(1)) && !empty_o);

    a_r4_pop_steps_up: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_POP && !empty_o) |=> (sp_o == $past(sp_o) + PTR_W'(1)) && !full_o);

    a_r6_push_when_full: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_PUSH && full_o) |=> err_o && $stable(sp_o) && full_o);

    a_r7_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_POP && empty_o) |=> err_o && $stable(sp_o) && $stable(dout_o));

    a_r10_fold_needs_two: assert property (@(posedge clk) disable iff (rst)
        ((op_i == OP_ADD || op_i == OP_MUL) && sp_o > PTR_W'(DEPTH - 2))
        |=> err_o && $stable(sp_o));

    a_r11_idle_codes: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd0 || op_i > 3'd4) |=> !err_o && $stable(sp_o) && $stable(dout_o));
endmodule

bind lifo_stack_engine lifo_stack_engine_chk #(
    .DEPTH (DEPTH),
    .WIDTH (WIDTH),
    .PTR_W (PTR_W)
) chk_i (.*);

// File: tb/lifo_stack_engine_tb_top.sv
`timescale 1ns/100ps
module lifo_stack_engine_tb_top;
    localparam int DEPTH = 11;
    localparam logic [2:0] C_IDLE = 3'd0;
    localparam logic [2:0] C_PUSH = 3'd1;
    localparam logic [2:0] C_POP  = 3'd2;
    localparam logic [2:0] C_ADD  = 3'd3;
    localparam logic [2:0] C_MUL  = 3'd4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_r = 3'd0;
    logic [15:0] din_r = '0;
    logic [15:0] dout;
    logic [3:0]  sp;
    logic        full, empty, err;

    int n_cmp = 0;
    int n_bad = 0;

    logic [15:0] model[$];
    logic [15:0] exp_dout = '0;
    logic        exp_err  = 1'b0;

    always #2.5 clk = ~clk;

    lifo_stack_engine dut_i (
        .clk(clk), .rst(rst), .op_i(op_r), .din_i(din_r),
        .dout_o(dout), .sp_o(sp), .full_o(full), .empty_o(empty), .err_o(err)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Model of the requirements: apply one command, wait one edge.
    task automatic step(input logic [2:0] opc, input logic [15:0] d);
        logic [15:0] a, b;
        exp_err = 1'b0;
        case (opc)
            C_PUSH: if (model.size() == DEPTH) exp_err = 1'b1; else model.push_back(d);
            C_POP:  if (model.size() == 0) exp_err = 1'b1; else exp_dout = model.pop_back();
            C_ADD, C_MUL:
                if (model.size() < 2) exp_err = 1'b1;
                else begin
                    a = model.pop_back();
                    b = model.pop_back();
                    if (opc == C_ADD) model.push_back(a + b);
                    else              model.push_back(a * b);
                end
            default: ;
        endcase
        op_r  = opc;
        din_r = d;
        @(negedge clk);
        op_r  = C_IDLE;
    endtask

    task automatic check_state(input string tag);
        check({tag, " sp"},    int'(sp),    DEPTH - model.size());
        check({tag, " full"},  int'(full),  int'(model.size() == DEPTH));
        check({tag, " empty"}, int'(empty), int'(model.size() == 0));
        check({tag, " err"},   int'(err),   int'(exp_err));
        check({tag, " dout"},  int'(dout),  int'(exp_dout));
    endtask

    task automatic t_reset();
        check("R1 sp", int'(sp), 11);
        check("R1 empty", int'(empty), 1);
        check("R1 full", int'(full), 0);
        check("R1 err", int'(err), 0);
        check("R1 dout", int'(dout), 0);
    endtask

    task automatic t_fill_drain();
        for (int i = 0; i < DEPTH; i++) begin
            step(C_PUSH, 16'(100 + 7 * i));
            check_state(i == DEPTH - 1 ? "R3 full after eleventh push" : "R2 push");
        end
        step(C_PUSH, 16'hDEAD);
        check_state("R6 push while full");
        check("R6 err pulse", int'(err), 1);
        step(C_IDLE, '0);
        check("R6 err one cycle", int'(err), 0);
        for (int i = DEPTH - 1; i >= 0; i--) begin
            step(C_POP, '0);
            check("R4 lifo order", int'(dout), 100 + 7 * i);
            check_state(i == 0 ? "R5 empty after last pop" : "R4 pop");
        end
        step(C_POP, '0);
        check_state("R7 pop while empty");
        check("R7 dout kept", int'(dout), 100);
        step(C_IDLE, '0);
        check("R7 err one cycle", int'(err), 0);
    endtask

    task automatic t_postfix();
        step(C_PUSH, 16'd3); step(C_PUSH, 16'd4);
        step(C_MUL, '0);  check_state("R9 mul");
        step(C_PUSH, 16'd5); step(C_PUSH, 16'd6);
        step(C_MUL, '0);  check_state("R9 mul second");
        step(C_ADD, '0);  check_state("R8 add");
        check("R12 one entry left", int'(sp), 10);
        step(C_POP, '0);
        check("R12 result", int'(dout), 42);
        check("R12 empty", int'(empty), 1);
    endtask

    task automatic t_fold_reject();
        step(C_ADD, '0);  check_state("R10 add on empty");
        check("R10 err", int'(err), 1);
        step(C_PUSH, 16'd7);
        step(C_MUL, '0);  check_state("R10 mul on one entry");
        check("R10 sp kept", int'(sp), 10);
        step(C_POP, '0);  check("R10 entry intact", int'(dout), 7);
        check_state("R10 drained");
    endtask

    task automatic t_wrap();
        step(C_PUSH, 16'hFFFF); step(C_PUSH, 16'd2);
        step(C_ADD, '0); step(C_POP, '0);
        check("R8 sum wraps", int'(dout), 1);
        step(C_PUSH, 16'd300); step(C_PUSH, 16'd300);
        step(C_MUL, '0); step(C_POP, '0);
        check("R9 product low bits", int'(dout), 24464);
        check_state("R9 drained");
    endtask

    task automatic t_idle_codes();
        step(C_PUSH, 16'd9);
        for (int c = 5; c < 8; c++) begin
            step(3'(c), 16'd55);
            check_state("R11 unused code");
        end
        step(C_IDLE, 16'd77); check_state("R11 idle");
        step(C_POP, '0);
        check("R11 stack untouched", int'(dout), 9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fill_drain();
        t_postfix();
        t_fold_reject();
        t_wrap();
        t_idle_codes();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule